// File: doc/BRIEF.md
# Flash Operation Status Formatter

This block builds the byte a host reads back from a flash device while an embedded program or erase algorithm is running, and drives the device's ready/busy line. The command decoder and the erase/program sequencer sit outside it. They tell the block which kind of operation is current and whether it is running, suspended, past its pulse limit, or still in its sector-load window. The block turns those flags into polling bits and toggle bits. Array read data is multiplexed elsewhere, and only while no status is being shown.

Each host read is marked by a strobe. The block advances its toggle flip-flops once per rising edge of that strobe. One toggle follows the whole operation. A second toggle advances only for reads whose address falls in a sector marked for erase. A program aimed at a protected sector gives a short busy window of fixed length, during which the operation toggle still moves, and then the device goes back to array reads.

Top module: `flash_status_gen`

## Requirements
- R1: While reset is held, and after it is released, `status` is 0x00 and `ready` is 1 until an operation is presented.
- R2: When `op_kind` is 0 (none) or 3 (reserved), `status` is 0x00 and `ready` is 1, whatever the other inputs are.
- R3: For `op_kind` 1 (program), bit 7 of `status` is the inverse of `wdata[7]` while the operation is working, and equals `wdata[7]` once it is not.
- R4: For `op_kind` 2 (erase), bit 7 of `status` is 0 while the operation is working and 1 otherwise.
- R5: Bit 6 of `status` inverts once per rising edge of `rd_stb` while the operation is working (`busy`, or the protected-program window open). It holds its value when the operation is idle or suspended. A strobe held high counts as one read.
- R6: Bit 2 of `status` inverts once per rising edge of `rd_stb` when `sel_sector` is 1 and either an erase is busy or `suspended` is 1. It is visible for an erase or while `suspended` is 1, and reads 0 otherwise.
- R7: Bit 5 of `status` equals `timeout` while an operation is presented.
- R8: Bit 3 of `status` equals `erase_run` for an erase (0 means the sector-load window is open, 1 means the internal erase has begun), and reads 0 for a program.
- R9: `ready` is 0 while the operation is working, which includes a program run during erase suspend. It is 1 when the operation is idle or only suspended.
- R10: An `op_start` pulse with `op_kind` 1 and `prot_hit` 1 keeps the operation working for exactly `GUARD_CYCLES` clock cycles even with `busy` at 0. Bit 6 toggles during that time and `ready` is 0.
- R11: An `op_start` pulse clears both toggle flip-flops, so bits 6 and 2 read 0 in the following cycle. The clear wins over a strobe edge in the same cycle.
- R12: Bits 4, 1 and 0 of `status` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_kind | input | 2 | 0 none, 1 program, 2 erase, 3 reserved |
| op_start | input | 1 | One-cycle pulse when a new operation is accepted |
| busy | input | 1 | Embedded algorithm is running |
| suspended | input | 1 | Erase is suspended |
| timeout | input | 1 | Internal pulse count limit exceeded |
| erase_run | input | 1 | Internal erase has begun (load window closed) |
| prot_hit | input | 1 | Program target lies in a protected sector (sampled with op_start) |
| wdata | input | 8 | Data byte being programmed |
| rd_stb | input | 1 | Host read strobe, one rising edge per read |
| sel_sector | input | 1 | Read address lies in a sector selected for erase |
| status | output | 8 | Status byte |
| ready | output | 1 | 1 ready, 0 busy |

## Verification
The assertions assume that `op_kind` stays constant while an operation is current. They also assume that `op_start` is a single-cycle pulse and that `rd_stb` is low during reset. The stability check on bit 6 applies only across cycles where `op_kind` has not changed. The random stimulus starts a new operation on about one cycle in sixteen and changes `op_kind` only together with `op_start`. It drives `rd_stb` low for the whole reset, and it flips the sequencer flags on their own so that suspend, timeout and the load window combine freely. Directed passes add a strobe held high, a start pulse that coincides with a strobe edge, and a complete protected-program window.

// File: rtl/flash_stat_pkg.sv
// Shared encodings for the flash status formatter.
// Assumes op_kind is driven by the command decoder with these codes.
package flash_stat_pkg;
    typedef enum logic [1:0] {
        OPK_NONE  = 2'd0,
        OPK_PROG  = 2'd1,
        OPK_ERASE = 2'd2,
        OPK_RSVD  = 2'd3
    } opk_t;

    // Bit positions inside the status byte (host software decodes these)
    localparam int unsigned SB_POLL   = 7;
    localparam int unsigned SB_TOG_OP = 6;
    localparam int unsigned SB_LIMIT  = 5;
    localparam int unsigned SB_WINDOW = 3;
    localparam int unsigned SB_TOG_SC = 2;

    // Toggle flip-flop indices
    localparam int unsigned TG_OP  = 0;
    localparam int unsigned TG_SEC = 1;
    localparam int unsigned NTOG   = 2;
endpackage

// File: rtl/fst_edge.sv
// Rising-edge detector for the host read strobe.
// Assumes the strobe is synchronous to clk; one pulse per low-to-high change.
module fst_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    // Remember the strobe level of the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/fst_toggle.sv
// Single toggle bit: cleared by a new operation, inverted on advance.
// Assumes clr takes priority over adv in the same cycle.
module fst_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic adv,
    output logic q
);
    // Clear on new operation, otherwise invert on each advance
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (clr) q <= 1'b0;
        else if (adv) q <= ~q;
    end
endmodule

// File: rtl/fst_guard.sv
// Countdown for the short busy window of a program aimed at a protected sector.
// Assumes start is a one-cycle pulse; arm is sampled only with start.
module fst_guard #(
    parameter int unsigned GUARD_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic arm,
    output logic active
);
    localparam int unsigned CW = $clog2(GUARD_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Load on an armed start, clear on an unarmed one, else count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (start)       cnt <= arm ? CW'(GUARD_CYCLES) : '0;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);
endmodule

// File: rtl/flash_status_gen.sv
// Status byte and ready/busy generator for embedded program/erase operations.
// Assumes op_kind is held for the life of an operation and op_start marks its
// first cycle; all inputs are synchronous to clk.
module flash_status_gen
    import flash_stat_pkg::*;
#(
    parameter int unsigned GUARD_CYCLES = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] op_kind,
    input  logic       op_start,
    input  logic       busy,
    input  logic       suspended,
    input  logic       timeout,
    input  logic       erase_run,
    input  logic       prot_hit,
    input  logic [7:0] wdata,
    input  logic       rd_stb,
    input  logic       sel_sector,
    output logic [7:0] status,
    output logic       ready
);
    opk_t            opk;
    logic            op_live;
    logic            is_prog;
    logic            is_erase;
    logic            guard_on;
    logic            working;
    logic            rd_rise;
    logic [NTOG-1:0] adv;
    logic [NTOG-1:0] tog;

    assign opk      = opk_t'(op_kind);
    assign is_prog  = (opk == OPK_PROG);
    assign is_erase = (opk == OPK_ERASE);
    assign op_live  = is_prog | is_erase;

    fst_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (rd_stb),
        .rise  (rd_rise)
    );

    fst_guard #(.GUARD_CYCLES(GUARD_CYCLES)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (op_start),
        .arm    (prot_hit & is_prog),
        .active (guard_on)
    );

    assign working = op_live & (busy | guard_on);

    // Advance conditions: one per operation, one per selected sector
    always_comb begin
        adv         = '0;
        adv[TG_OP]  = rd_rise & working;
        adv[TG_SEC] = rd_rise & sel_sector & op_live & ((is_erase & busy) | suspended);
    end

    for (genvar g = 0; g < NTOG; g++) begin : g_tog
        fst_toggle u_tog (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (op_start),
            .adv   (adv[g]),
            .q     (tog[g])
        );
    end

    // Assemble the status byte from the operation flags and toggle bits
    always_comb begin
        status = '0;
        if (op_live) begin
            if (is_prog) status[SB_POLL] = working ? ~wdata[7] : wdata[7];
            else         status[SB_POLL] = ~working;
            status[SB_TOG_OP] = tog[TG_OP];
            status[SB_LIMIT]  = timeout;
            status[SB_WINDOW] = is_erase & erase_run;
            if (is_erase | suspended) status[SB_TOG_SC] = tog[TG_SEC];
        end
    end

    assign ready = ~working;
endmodule

// File: rtl/flash_status_gen_chk.sv
// Property checker for flash_status_gen, attached by bind.
// Assumes op_kind only changes alongside op_start and rd_stb is low in reset.
module flash_status_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] op_kind,
    input logic       op_start,
    input logic       busy,
    input logic       suspended,
    input logic       timeout,
    input logic       erase_run,
    input logic       prot_hit,
    input logic [7:0] wdata,
    input logic       rd_stb,
    input logic       sel_sector,
    input logic [7:0] status,
    input logic       ready
);
    logic rd_prev;
    logic live;

    // Track the previous strobe level independently of the design
    always_ff @(posedge clk) begin
        if (!rst_n) rd_prev <= 1'b0;
        else        rd_prev <= rd_stb;
    end

    assign live = (op_kind == 2'd1) || (op_kind == 2'd2);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> (status == 8'h00 && ready));

    // R3
    prog_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 2'd1 && busy) |-> (status[7] == ~wdata[7]));

    // R4
    erase_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == 2'd2 && busy) |-> (status[7] == 1'b0));

    // R9
    busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && busy) |-> !ready);

    // R5
    tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $stable(op_kind) && !$past(op_start) && !$past(rd_stb && !rd_prev))
        |-> (status[6] == $past(status[6])));

    // R11
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> (status[6] == 1'b0 && status[2] == 1'b0));
endmodule

bind flash_status_gen flash_status_gen_chk u_chk (.*);

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;
    localparam int GUARD = 100;
    localparam int NRAND = 4000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_kind = 2'd0;
    logic       op_start = 1'b0;
    logic       busy = 1'b0;
    logic       suspended = 1'b0;
    logic       timeout = 1'b0;
    logic       erase_run = 1'b0;
    logic       prot_hit = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       rd_stb = 1'b0;
    logic       sel_sector = 1'b0;
    logic [7:0] status;
    logic       ready;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model state
    bit m_rdq = 0;
    bit m_top = 0;
    bit m_tsc = 0;
    int m_g = 0;

    flash_status_gen #(.GUARD_CYCLES(GUARD)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .op_start(op_start),
        .busy(busy), .suspended(suspended), .timeout(timeout),
        .erase_run(erase_run), .prot_hit(prot_hit), .wdata(wdata),
        .rd_stb(rd_stb), .sel_sector(sel_sector), .status(status), .ready(ready)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic bit m_live();
        return (op_kind == 2'd1) || (op_kind == 2'd2);
    endfunction

    function automatic bit m_work();
        return m_live() && (busy || m_g != 0);
    endfunction

    // Advance the model over the coming clock edge with the present inputs
    task automatic model_step();
        bit edge_seen;
        edge_seen = rd_stb && !m_rdq;
        if (op_start) begin
            m_top = 0;
            m_tsc = 0;
        end else begin
            if (edge_seen && m_work()) m_top = ~m_top;
            if (edge_seen && sel_sector && m_live() &&
                ((op_kind == 2'd2 && busy) || suspended)) m_tsc = ~m_tsc;
        end
        if (op_start) m_g = (prot_hit && op_kind == 2'd1) ? GUARD : 0;
        else if (m_g != 0) m_g--;
        m_rdq = rd_stb;
    endtask

    // Compare every status field and ready against the model
    task automatic check_all();
        bit e7;
        if (!m_live()) begin
            chk(status == 8'h00, "R2", status, 0);
            chk(ready == 1'b1, "R2", ready, 1);
            return;
        end
        if (op_kind == 2'd1) begin
            e7 = m_work() ? ~wdata[7] : wdata[7];
            chk(status[7] == e7, "R3", status[7], e7);
        end else begin
            e7 = ~m_work();
            chk(status[7] == e7, "R4", status[7], e7);
        end
        chk(status[6] == m_top, (m_g != 0) ? "R10" : "R5", status[6], m_top);
        chk(status[5] == timeout, "R7", status[5], timeout);
        chk(status[3] == (op_kind == 2'd2 && erase_run), "R8", status[3],
            (op_kind == 2'd2 && erase_run));
        chk(status[2] == ((op_kind == 2'd2 || suspended) ? m_tsc : 1'b0), "R6",
            status[2], ((op_kind == 2'd2 || suspended) ? m_tsc : 1'b0));
        chk({status[4], status[1], status[0]} == 3'b000, "R12",
            {status[4], status[1], status[0]}, 0);
        chk(ready == ~m_work(), "R9", ready, ~m_work());
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        #(20 * 200000);
        chk(1'b0, "watchdog", 0, 1);
        report();
    end

    initial begin
        int cnt;
        void'($urandom(32'd20240611));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(status == 8'h00, "R1", status, 0);
        chk(ready == 1'b1, "R1", ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status == 8'h00 && ready, "R1", {ready, status}, 9'h100);

        // Directed: program, polling and held strobe (R3, R5)
        op_kind = 2'd1; wdata = 8'h80; busy = 1'b1; op_start = 1'b1;
        tick();
        op_start = 1'b0;
        chk(status[7] == 1'b0, "R3", status[7], 0);
        rd_stb = 1'b1;
        repeat (4) tick();
        chk(status[6] == 1'b1, "R5", status[6], 1);
        rd_stb = 1'b0; tick();
        rd_stb = 1'b1; tick();
        rd_stb = 1'b0; tick();
        chk(status[6] == 1'b0, "R5", status[6], 0);
        rd_stb = 1'b1; tick();
        // R11: start pulse with a strobe edge in the same cycle
        rd_stb = 1'b0; tick();
        rd_stb = 1'b1; op_start = 1'b1; tick();
        op_start = 1'b0; rd_stb = 1'b0;
        chk(status[6] == 1'b0, "R11", status[6], 0);
        busy = 1'b0; tick();
        chk(status[7] == 1'b1 && ready, "R3", {ready, status[7]}, 3);

        // Directed: protected program window (R10)
        prot_hit = 1'b1; op_start = 1'b1; tick();
        op_start = 1'b0; prot_hit = 1'b0;
        cnt = ready ? 0 : 1;
        for (int i = 0; i < GUARD + 5; i++) begin
            if (ready) break;
            rd_stb = ~rd_stb;
            tick();
            if (!ready) cnt++;
        end
        chk(cnt == GUARD, "R10", cnt, GUARD);
        rd_stb = 1'b0;

        // Directed: erase with sector toggle during suspend (R6, R8)
        op_kind = 2'd2; busy = 1'b1; erase_run = 1'b0; op_start = 1'b1; tick();
        op_start = 1'b0; sel_sector = 1'b1;
        chk(status[3] == 1'b0, "R8", status[3], 0);
        busy = 1'b0; suspended = 1'b1;
        rd_stb = 1'b1; tick();
        chk(status[2] == 1'b1 && ready, "R6", {ready, status[2]}, 3);
        rd_stb = 1'b0; suspended = 1'b0; erase_run = 1'b1; busy = 1'b1; tick();

        // Random phase
        for (int i = 0; i < NRAND; i++) begin
            op_start = ($urandom % 16) == 0;
            if (op_start) begin
                op_kind  = 2'($urandom % 4);
                prot_hit = ($urandom % 3) == 0;
                wdata    = 8'($urandom);
            end else begin
                prot_hit = 1'b0;
            end
            if (($urandom % 20) == 0) busy = ~busy;
            if (($urandom % 10) == 0) suspended = ~suspended;
            if (($urandom % 40) == 0) timeout = ~timeout;
            if (($urandom % 20) == 0) erase_run = ~erase_run;
            rd_stb     = ($urandom % 2) == 1;
            sel_sector = ($urandom % 2) == 1;
            tick();
        end
        report();
    end
endmodule